// File: doc/BRIEF.md
# Clock Source Selection Commit Controller

This block runs on a 40 MHz configuration clock. It keeps the clock-source selection for four clock paths: acquisition, PFI, generation and a global clock. Each path has a source-code request input. When the write strobe goes from low to high, the block checks all four requests as one set. If the set is acceptable, the block copies it into the committed selection outputs, which feed a downstream routing switch.

Programming the switch itself is not modelled. It is represented by a fixed busy window, and the ready flag is low for the length of that window. A request set that breaks the encoding rules, or that asks for the strobe in two incompatible ways, is refused. When a set is refused, the committed selection does not change and an error flag is raised.

Top module: `clksel_commit_ctrl`

## Requirements
- R1: After reset, all four committed selections are 0, `ready` is 1 and `err` is 0.
- R2: The source encodings are: 0 for off (tristate), 2 for the backplane clock, 3 for the onboard oscillator, 4 for the strobe routed through the switch, and 5 for the strobe that bypasses the switch. A write whose paths use only accepted codes is committed. The acquisition path may use any of 0, 2, 3, 4 and 5.
- R3: Code 5 on the PFI, generation or global path causes the whole write to be rejected.
- R4: Code 1, and every code from 6 to 255, causes the write to be rejected, whichever path carries it.
- R5: A write is rejected when acquisition requests code 5 and any other path requests code 4. Code 4 on several paths is accepted when acquisition is not 5.
- R6: A write is evaluated only on a 0-to-1 transition of `wr_strobe`. Holding the strobe high, changing the requests while it is high, or lowering it does not commit anything.
- R7: On an accepted write, the selections take the requested codes and `ready` goes to 0 in the clock cycle after the edge that samples the rising strobe. `ready` then stays 0 for exactly 32 cycles, and `err` goes to 0.
- R8: A rising strobe while `ready` is 0 is ignored. It changes neither the selections nor `err`, and it does not lengthen the busy window.
- R9: On a rejected write, all selections keep their previous values, `ready` stays 1, and `err` becomes 1. `err` stays 1 until the next write that is evaluated.
- R10: The committed selections change only through an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock (40 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| req_acq | input | 8 | Requested source code for the acquisition path |
| req_pfi | input | 8 | Requested source code for the PFI path |
| req_gen | input | 8 | Requested source code for the generation path |
| req_glb | input | 8 | Requested source code for the global clock path |
| wr_strobe | input | 1 | Write request; evaluated on its rising transition |
| ready | output | 1 | High when a new write can be taken |
| err | output | 1 | High after a rejected write, until the next evaluated write |
| sel_acq | output | 8 | Committed acquisition source |
| sel_pfi | output | 8 | Committed PFI source |
| sel_gen | output | 8 | Committed generation source |
| sel_glb | output | 8 | Committed global clock source |

## Verification
The busy counter could be loaded with the wrong value or restarted by an ignored strobe. That fault shows up as a `ready` low time that is not 32 cycles, and it is measured from the first cycle after the accepting edge.

A validator fault shows up on the cycle right after the strobe edge. The selections change when they should have been kept, or `err` takes the wrong value.

A faulty edge detector shows up as a second commit while the strobe is held high, or as a commit when the strobe falls. Either one is visible within a cycle of the stimulus.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  localparam int unsigned CODE_W = 8;
  localparam int unsigned PATHS  = 4;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    PATH_ACQ = 2'd0,
    PATH_PFI = 2'd1,
    PATH_GEN = 2'd2,
    PATH_GLB = 2'd3
  } path_e;

  localparam code_t SRC_OFF        = code_t'(0);
  localparam code_t SRC_BACKPLANE  = code_t'(2);
  localparam code_t SRC_OSC        = code_t'(3);
  localparam code_t SRC_STROBE_SW  = code_t'(4);
  localparam code_t SRC_STROBE_BYP = code_t'(5);

  // Code legality for one path; the bypass code belongs to acquisition only.
  function automatic logic code_legal(input code_t code, input logic is_acq);
    logic ok;
    ok = (code == SRC_OFF) || (code == SRC_BACKPLANE) ||
         (code == SRC_OSC) || (code == SRC_STROBE_SW);
    if (is_acq && (code == SRC_STROBE_BYP)) ok = 1'b1;
    return ok;
  endfunction

  // True when a non-acquisition path wants the switched strobe while
  // acquisition has taken the strobe on its bypass route.
  function automatic logic strobe_clash(input code_t acq_code, input code_t other_code);
    return (acq_code == SRC_STROBE_BYP) && (other_code == SRC_STROBE_SW);
  endfunction

endpackage

// File: rtl/clksel_edge_detect.sv
module clksel_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i && !strobe_q;
endmodule

// File: rtl/clksel_validator.sv
module clksel_validator
  import clksel_pkg::*;
(
  input  code_t [PATHS-1:0] req_i,
  output logic              valid_o
);
  logic [PATHS-1:0] path_ok;
  logic [PATHS-1:0] path_clash;

  for (genvar p = 0; p < PATHS; p++) begin : g_path
    localparam logic IS_ACQ = (p == int'(PATH_ACQ));
    assign path_ok[p] = code_legal(req_i[p], IS_ACQ);
    if (IS_ACQ) begin : g_acq
      assign path_clash[p] = 1'b0;
    end else begin : g_other
      assign path_clash[p] = strobe_clash(req_i[PATH_ACQ], req_i[p]);
    end
  end

  assign valid_o = (&path_ok) && !(|path_clash);
endmodule

// File: rtl/clksel_busy_timer.sv
module clksel_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain_q <= '0;
    else if (start_i)        remain_q <= LOAD;
    else if (remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign ready_o = (remain_q == '0);
endmodule

// File: rtl/clksel_sel_bank.sv
module clksel_sel_bank
  import clksel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  code_t [PATHS-1:0] req_i,
  output code_t [PATHS-1:0] sel_o
);
  for (genvar p = 0; p < PATHS; p++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)      sel_o[p] <= SRC_OFF;
      else if (load_i) sel_o[p] <= req_i[p];
    end
  end
endmodule

// File: rtl/clksel_commit_ctrl.sv
module clksel_commit_ctrl
  import clksel_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] req_acq,
  input  logic [CODE_W-1:0] req_pfi,
  input  logic [CODE_W-1:0] req_gen,
  input  logic [CODE_W-1:0] req_glb,
  input  logic              wr_strobe,
  output logic              ready,
  output logic              err,
  output logic [CODE_W-1:0] sel_acq,
  output logic [CODE_W-1:0] sel_pfi,
  output logic [CODE_W-1:0] sel_gen,
  output logic [CODE_W-1:0] sel_glb
);
  // Named internal events, also observed by the bound checker.
  logic wr_rise;
  logic req_valid;
  logic accept;
  logic reject;

  code_t [PATHS-1:0] req_vec;
  code_t [PATHS-1:0] sel_vec;

  assign req_vec[PATH_ACQ] = req_acq;
  assign req_vec[PATH_PFI] = req_pfi;
  assign req_vec[PATH_GEN] = req_gen;
  assign req_vec[PATH_GLB] = req_glb;

  clksel_edge_detect u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (wr_strobe),
    .rise_o   (wr_rise)
  );

  clksel_validator u_valid (
    .req_i   (req_vec),
    .valid_o (req_valid)
  );

  assign accept = wr_rise && ready && req_valid;
  assign reject = wr_rise && ready && !req_valid;

  clksel_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept),
    .ready_o (ready)
  );

  clksel_sel_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .req_i  (req_vec),
    .sel_o  (sel_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      err <= 1'b0;
    else if (accept) err <= 1'b0;
    else if (reject) err <= 1'b1;
  end

  assign sel_acq = sel_vec[PATH_ACQ];
  assign sel_pfi = sel_vec[PATH_PFI];
  assign sel_gen = sel_vec[PATH_GEN];
  assign sel_glb = sel_vec[PATH_GLB];
endmodule

// File: rtl/clksel_commit_ctrl_chk.sv
module clksel_commit_ctrl_chk
  import clksel_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 32
) (
  input logic  clk,
  input logic  rst_n,
  input logic  ready,
  input logic  err,
  input code_t req_acq,
  input code_t req_pfi,
  input code_t req_gen,
  input code_t req_glb,
  input code_t sel_acq,
  input code_t sel_pfi,
  input code_t sel_gen,
  input code_t sel_glb,
  input logic  wr_rise,
  input logic  accept,
  input logic  reject
);
  localparam int unsigned RUN_W = $clog2(BUSY_CYCLES + 2);
  localparam logic [RUN_W-1:0] LAST = RUN_W'(BUSY_CYCLES - 1);

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)     low_run <= '0;
    else if (!ready) low_run <= low_run + 1'b1;
    else            low_run <= '0;
  end

  AST_ACCEPT_LOADS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (sel_acq == $past(req_acq)) && (sel_pfi == $past(req_pfi)) &&
               (sel_gen == $past(req_gen)) && (sel_glb == $past(req_glb)) && !err); // R7
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && (low_run < LAST)) |=> !ready); // R7
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && (low_run == LAST)) |=> ready); // R8
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err && ready && $stable(sel_acq) && $stable(sel_pfi) &&
               $stable(sel_gen) && $stable(sel_glb)); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(sel_acq) && $stable(sel_pfi) && $stable(sel_gen) && $stable(sel_glb)); // R10
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !ready) |=> $stable(err)); // R8
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code_legal(sel_acq, 1'b1) && code_legal(sel_pfi, 1'b0) &&
    code_legal(sel_gen, 1'b0) && code_legal(sel_glb, 1'b0)); // R3
  AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_clash(sel_acq, sel_pfi) || strobe_clash(sel_acq, sel_gen) ||
      strobe_clash(sel_acq, sel_glb))); // R5
endmodule

bind clksel_commit_ctrl clksel_commit_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ready   (ready),
  .err     (err),
  .req_acq (req_acq),
  .req_pfi (req_pfi),
  .req_gen (req_gen),
  .req_glb (req_glb),
  .sel_acq (sel_acq),
  .sel_pfi (sel_pfi),
  .sel_gen (sel_gen),
  .sel_glb (sel_glb),
  .wr_rise (wr_rise),
  .accept  (accept),
  .reject  (reject)
);

// File: tb/clksel_commit_ctrl_tb.sv
module clksel_commit_ctrl_tb;
  localparam int BUSY = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_acq = '0, req_pfi = '0, req_gen = '0, req_glb = '0;
  logic       wr_strobe = 1'b0;
  logic       ready, err;
  logic [7:0] sel_acq, sel_pfi, sel_gen, sel_glb;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  clksel_commit_ctrl #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_acq(req_acq), .req_pfi(req_pfi), .req_gen(req_gen), .req_glb(req_glb),
    .wr_strobe(wr_strobe), .ready(ready), .err(err),
    .sel_acq(sel_acq), .sel_pfi(sel_pfi), .sel_gen(sel_gen), .sel_glb(sel_glb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_sel(input string tag, input logic [7:0] a, input logic [7:0] p,
                           input logic [7:0] g, input logic [7:0] b);
    check({tag, " sel_acq"}, sel_acq, a);
    check({tag, " sel_pfi"}, sel_pfi, p);
    check({tag, " sel_gen"}, sel_gen, g);
    check({tag, " sel_glb"}, sel_glb, b);
  endtask

  // Pulse the strobe for one cycle; returns on the negedge after the sampling edge.
  task automatic do_write(input logic [7:0] a, input logic [7:0] p,
                          input logic [7:0] g, input logic [7:0] b);
    @(negedge clk);
    req_acq = a; req_pfi = p; req_gen = g; req_glb = b;
    wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  // Counts negedges (including the current one) with ready low.
  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check_sel("R1 reset", 8'd0, 8'd0, 8'd0, 8'd0);
    check("R1 reset ready", ready, 1);
    check("R1 reset err", err, 0);
  endtask

  task automatic t_accept_basic;
    int n;
    do_write(8'd3, 8'd2, 8'd4, 8'd0);
    check_sel("R2 accept", 8'd3, 8'd2, 8'd4, 8'd0);
    check("R7 ready low after accept", ready, 0);
    check("R7 err after accept", err, 0);
    busy_len(n);
    check("R7 busy length", n, BUSY);
  endtask

  task automatic t_bypass;
    int n;
    do_write(8'd5, 8'd3, 8'd2, 8'd0);
    check_sel("R2 bypass on acq", 8'd5, 8'd3, 8'd2, 8'd0);
    check("R2 bypass err", err, 0);
    busy_len(n);
  endtask

  task automatic t_nonacq_five;
    do_write(8'd2, 8'd5, 8'd2, 8'd2);
    check_sel("R3 pfi code 5 kept", 8'd5, 8'd3, 8'd2, 8'd0);
    check("R3 err set", err, 1);
    check("R9 ready stays high", ready, 1);
    do_write(8'd0, 8'd0, 8'd0, 8'd5);
    check_sel("R3 glb code 5 kept", 8'd5, 8'd3, 8'd2, 8'd0);
    check("R9 err held", err, 1);
  endtask

  task automatic t_error_clears;
    int n;
    do_write(8'd2, 8'd2, 8'd3, 8'd3);
    check_sel("R9 valid after error", 8'd2, 8'd2, 8'd3, 8'd3);
    check("R9 err cleared", err, 0);
    busy_len(n);
  endtask

  task automatic t_bad_codes;
    do_write(8'd1, 8'd0, 8'd0, 8'd0);
    check("R4 code 1 err", err, 1);
    check_sel("R4 code 1 kept", 8'd2, 8'd2, 8'd3, 8'd3);
    do_write(8'd0, 8'd0, 8'd6, 8'd0);
    check("R4 code 6 err", err, 1);
    check("R4 code 6 ready", ready, 1);
    do_write(8'd0, 8'd0, 8'd0, 8'hFF);
    check_sel("R4 code 255 kept", 8'd2, 8'd2, 8'd3, 8'd3);
  endtask

  task automatic t_conflict;
    int n;
    do_write(8'd5, 8'd0, 8'd4, 8'd0);
    check("R5 conflict err", err, 1);
    check_sel("R5 conflict kept", 8'd2, 8'd2, 8'd3, 8'd3);
    do_write(8'd4, 8'd4, 8'd4, 8'd4);
    check_sel("R5 shared strobe ok", 8'd4, 8'd4, 8'd4, 8'd4);
    check("R5 shared strobe err", err, 0);
    busy_len(n);
  endtask

  task automatic t_busy_ignore;
    int n;
    do_write(8'd2, 8'd2, 8'd2, 8'd2);
    check("R7 ready low", ready, 0);
    do_write(8'd3, 8'd3, 8'd3, 8'd3);
    check_sel("R8 busy write ignored", 8'd2, 8'd2, 8'd2, 8'd2);
    do_write(8'd0, 8'd5, 8'd0, 8'd0);
    check("R8 busy bad write no err", err, 0);
    busy_len(n);
    check("R8 busy not extended", n + 4, BUSY);
    check_sel("R8 sel after busy", 8'd2, 8'd2, 8'd2, 8'd2);
  endtask

  task automatic t_held_strobe;
    int n;
    @(negedge clk);
    req_acq = 8'd3; req_pfi = 8'd3; req_gen = 8'd3; req_glb = 8'd3;
    wr_strobe = 1'b1;
    @(negedge clk);
    check_sel("R6 first edge commits", 8'd3, 8'd3, 8'd3, 8'd3);
    busy_len(n);
    req_acq = 8'd0; req_pfi = 8'd2; req_gen = 8'd0; req_glb = 8'd2;
    repeat (5) @(negedge clk);
    check_sel("R6 held strobe no commit", 8'd3, 8'd3, 8'd3, 8'd3);
    check("R6 held strobe ready", ready, 1);
    wr_strobe = 1'b0;
    repeat (2) @(negedge clk);
    check_sel("R10 falling edge no commit", 8'd3, 8'd3, 8'd3, 8'd3);
    check("R10 falling edge ready", ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_accept_basic();
    t_bypass();
    t_nonacq_five();
    t_error_clears();
    t_bad_codes();
    t_conflict();
    t_busy_ignore();
    t_held_strobe();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule